// File: doc/BRIEF.md
# Response Sequence Number Checker

On a split-transaction bus, data responses can come back long after their requests were issued. Each responder that asserts its send-data strobe also drives a 4-bit sequence tag at the same time. Every requester holds one copy of this checker. The checker watches every accepted send-data assertion on the bus, from any responder and not only the ones that complete local requests. It compares the tag on the bus with the tag it expects next. After each good response it moves the expected tag forward by one.

After reset the expected tag is zero. It advances modulo 16. A strobe seen while the bus hold line is high is not accepted, so it is neither counted nor checked. If a tag does not match, the checker raises a one-cycle fault flag and sets a sticky status bit. It also raises an abort request, which tells the surrounding logic to cancel all outstanding requests. After that first fault the checker stops checking and its expected tag stays frozen until reset, so a single error is reported only once.

The sticky status bit is cleared by reset or by a write-one-to-clear pulse. The abort request and the halted state are cleared only by reset. The expected tag is brought out as a port for debug.

Top module: `resp_seq_checker`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `expected_tag_o` is 0 and `oos_fault_o`, `oos_status_o` and `abort_req_o` are all 0.
- R2: When the strobe is accepted and the tag equals `expected_tag_o`, `expected_tag_o` is incremented by one after the clock edge. The value wraps from 15 to 0, and no fault is raised.
- R3: A strobe sampled while `hold_i` is 1 is ignored: `expected_tag_o` does not change and no fault is raised, even when the tag is wrong. A cycle with `send_data_i` at 0 is ignored in the same way, whatever the tag.
- R4: When the strobe is accepted and the tag differs from `expected_tag_o`, `oos_fault_o` is 1 on the cycle after that edge, and only on that cycle. `oos_status_o` is set on the same cycle.
- R5: `abort_req_o` rises on the same cycle as the fault pulse and stays at 1 until reset.
- R6: After a fault no strobe is accepted. `expected_tag_o` stays frozen and `oos_fault_o` stays at 0 until reset, whatever tags arrive.
- R7: A 1 on `status_clr_i` clears `oos_status_o` after the edge and leaves `abort_req_o` unchanged. If a new fault happens in the same cycle as the clear, the set wins.
- R8: Reset applied after a fault clears the halted state, and the tag sequence starts again at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_data_i | input | 1 | Responder send-data strobe |
| tag_i | input | 4 | Sequence tag driven with the strobe |
| hold_i | input | 1 | Bus hold; strobes seen while it is high are ignored |
| status_clr_i | input | 1 | Write-one-to-clear for the sticky status bit |
| oos_fault_o | output | 1 | One-cycle out-of-sequence fault pulse |
| oos_status_o | output | 1 | Sticky out-of-sequence status bit |
| abort_req_o | output | 1 | Request to abort all outstanding requests; held until reset |
| expected_tag_o | output | 4 | Tag expected on the next accepted strobe |

## Verification
The first pattern is a long run of in-order tags that passes the wrap from 15 to 0. It separates a correct modulo counter from one that saturates or skips a value. The second pattern sends wrong tags, first with hold high and then with the strobe low. It shows whether qualification happens before the compare and before the counter. The third pattern injects a single mismatch and follows it with more wrong and right tags. This separates a one-shot fault with a frozen expectation from a checker that keeps counting or reports again. The last patterns exercise the clear pulse, a clear that lands in the same cycle as a new fault, and a reset after a fault. They test the set-over-clear priority and the restart of the sequence at zero.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    parameter int TAG_W = 4;
    localparam int TAG_MOD = 1 << TAG_W;

    typedef logic [TAG_W-1:0] tag_t;

    // One qualified response as seen on the bus
    typedef struct packed {
        logic valid;
        tag_t tag;
    } resp_t;

    typedef enum logic {
        CHK_ACTIVE = 1'b0,
        CHK_HALTED = 1'b1
    } chk_state_e;

    function automatic tag_t tag_succ(input tag_t t);
        return tag_t'((int'(t) + 1) % TAG_MOD);
    endfunction

endpackage

// File: rtl/seq_accept.sv
module seq_accept
    import seqchk_pkg::*;
(
    input  logic  send_data,
    input  logic  hold,
    input  logic  halted,
    input  tag_t  tag,
    output resp_t resp
);
    always_comb begin
        resp.valid = send_data && !hold && !halted;
        resp.tag   = tag;
    end
endmodule

// File: rtl/seq_expect_ctr.sv
module seq_expect_ctr
    import seqchk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output tag_t expected
);
    tag_t exp_q;

    always_ff @(posedge clk) begin
        if (rst)
            exp_q <= '0;
        else if (advance)
            exp_q <= tag_succ(exp_q);
    end

    assign expected = exp_q;
endmodule

// File: rtl/seq_fault_ctl.sv
module seq_fault_ctl
    import seqchk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  resp_t resp,
    input  tag_t  expected,
    input  logic  status_clr,
    output logic  mismatch,
    output logic  fault_pulse,
    output logic  status_bit,
    output logic  halted
);
    chk_state_e state_q;
    logic       pulse_q;
    logic       sticky_q;

    assign mismatch = resp.valid && (resp.tag != expected);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CHK_ACTIVE;
            pulse_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            pulse_q <= mismatch;
            if (mismatch)
                state_q <= CHK_HALTED;
            // set has priority over a simultaneous clear
            if (mismatch)
                sticky_q <= 1'b1;
            else if (status_clr)
                sticky_q <= 1'b0;
        end
    end

    assign fault_pulse = pulse_q;
    assign status_bit  = sticky_q;
    assign halted      = (state_q == CHK_HALTED);
endmodule

// File: rtl/resp_seq_checker.sv
module resp_seq_checker
    import seqchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             send_data_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             hold_i,
    input  logic             status_clr_i,
    output logic             oos_fault_o,
    output logic             oos_status_o,
    output logic             abort_req_o,
    output logic [TAG_W-1:0] expected_tag_o
);
    resp_t resp;
    tag_t  expected;
    logic  mismatch;
    logic  halted;

    seq_accept u_accept (
        .send_data (send_data_i),
        .hold      (hold_i),
        .halted    (halted),
        .tag       (tag_i),
        .resp      (resp)
    );

    seq_expect_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .advance  (resp.valid && !mismatch),
        .expected (expected)
    );

    seq_fault_ctl u_fault (
        .clk         (clk),
        .rst         (rst),
        .resp        (resp),
        .expected    (expected),
        .status_clr  (status_clr_i),
        .mismatch    (mismatch),
        .fault_pulse (oos_fault_o),
        .status_bit  (oos_status_o),
        .halted      (halted)
    );

    assign abort_req_o    = halted;
    assign expected_tag_o = expected;
endmodule

module resp_seq_checker_sva
    import seqchk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             send_data_i,
    input logic [TAG_W-1:0] tag_i,
    input logic             hold_i,
    input logic             status_clr_i,
    input logic             oos_fault_o,
    input logic             oos_status_o,
    input logic             abort_req_o,
    input logic [TAG_W-1:0] expected_tag_o
);
    logic acc;
    assign acc = send_data_i && !hold_i && !abort_req_o;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (expected_tag_o == '0) && !oos_fault_o && !oos_status_o && !abort_req_o);

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (acc && tag_i == expected_tag_o) |=>
            (expected_tag_o == tag_t'($past(expected_tag_o) + 1'b1)) && !oos_fault_o);

    a_r3_hold_ignored: assert property (@(posedge clk) disable iff (rst)
        (send_data_i && hold_i) |=> $stable(expected_tag_o) && !oos_fault_o);

    a_r4_mismatch: assert property (@(posedge clk) disable iff (rst)
        (acc && tag_i != expected_tag_o) |=> oos_fault_o && oos_status_o);

    a_r5_abort_held: assert property (@(posedge clk) disable iff (rst)
        abort_req_o |=> abort_req_o);

    a_r5_abort_with_fault: assert property (@(posedge clk) disable iff (rst)
        $rose(oos_fault_o) |-> $rose(abort_req_o));

    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        abort_req_o |=> $stable(expected_tag_o) && !oos_fault_o);

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (status_clr_i && !(acc && tag_i != expected_tag_o)) |=> !oos_status_o);
endmodule

bind resp_seq_checker resp_seq_checker_sva i_sva (
    .clk            (clk),
    .rst            (rst),
    .send_data_i    (send_data_i),
    .tag_i          (tag_i),
    .hold_i         (hold_i),
    .status_clr_i   (status_clr_i),
    .oos_fault_o    (oos_fault_o),
    .oos_status_o   (oos_status_o),
    .abort_req_o    (abort_req_o),
    .expected_tag_o (expected_tag_o)
);

// File: tb/test_resp_seq_checker.sv
`timescale 1ns/1ps
module test_resp_seq_checker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       send_data = 1'b0;
    logic [3:0] tag = 4'd0;
    logic       hold = 1'b0;
    logic       clr = 1'b0;
    logic       fault, status, abort_req;
    logic [3:0] exp_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] exp_tag;
        logic       fault;
        logic       status;
        logic       abort_req;
        string      req;
    } item_t;

    item_t sb[$];

    // reference model state
    logic [3:0] m_exp = 4'd0;
    logic       m_stat = 1'b0;
    logic       m_halt = 1'b0;
    logic       m_fault = 1'b0;

    always #2 clk = ~clk;

    resp_seq_checker i_resp_seq_checker (
        .clk            (clk),
        .rst            (rst),
        .send_data_i    (send_data),
        .tag_i          (tag),
        .hold_i         (hold),
        .status_clr_i   (clr),
        .oos_fault_o    (fault),
        .oos_status_o   (status),
        .abort_req_o    (abort_req),
        .expected_tag_o (exp_tag)
    );

    // driver: apply one cycle of stimulus, update model, push expectation
    task automatic step(input logic r, input logic s, input logic [3:0] t,
                        input logic h, input logic c, input string req);
        item_t it;
        logic acc, mis;
        @(negedge clk);
        rst = r; send_data = s; tag = t; hold = h; clr = c;
        @(posedge clk);
        if (r) begin
            m_exp = 4'd0; m_stat = 1'b0; m_halt = 1'b0; m_fault = 1'b0;
        end else begin
            acc = s && !h && !m_halt;
            mis = acc && (t != m_exp);
            m_fault = mis;
            if (mis) m_stat = 1'b1;
            else if (c) m_stat = 1'b0;
            if (mis) m_halt = 1'b1;
            if (acc && !mis) m_exp = m_exp + 4'd1;
        end
        it.exp_tag = m_exp; it.fault = m_fault; it.status = m_stat;
        it.abort_req = m_halt; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compare at the falling edge after each driven edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (exp_tag !== it.exp_tag || fault !== it.fault ||
                status !== it.status || abort_req !== it.abort_req) begin
                errors++;
                $display("FAIL %s: got exp=%0d flt=%0b st=%0b ab=%0b, expected exp=%0d flt=%0b st=%0b ab=%0b",
                         it.req, exp_tag, fault, status, abort_req,
                         it.exp_tag, it.fault, it.status, it.abort_req);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state and first idle cycle
        step(1, 0, 4'd0, 0, 0, "R1");
        step(1, 0, 4'd0, 0, 0, "R1");
        step(0, 0, 4'd0, 0, 0, "R1");
        // R2: in-order tags across the wrap
        for (int i = 0; i < 20; i++)
            step(0, 1, 4'(i), 0, 0, "R2");
        // R3: wrong tags under hold, and with strobe low
        step(0, 1, 4'd9, 1, 0, "R3");
        step(0, 1, 4'd3, 1, 0, "R3");
        step(0, 0, 4'd7, 0, 0, "R3");
        step(0, 1, 4'd4, 0, 0, "R2");
        // R4/R5: mismatch
        step(0, 1, 4'd12, 0, 0, "R4");
        step(0, 0, 4'd0, 0, 0, "R5");
        // R6: further tags, wrong and right, are ignored
        step(0, 1, 4'd1, 0, 0, "R6");
        step(0, 1, 4'd5, 0, 0, "R6");
        step(0, 1, 4'd6, 0, 0, "R6");
        // R7: clear status, abort stays
        step(0, 0, 4'd0, 0, 1, "R7");
        step(0, 0, 4'd0, 0, 0, "R7");
        // R8: reset restarts at zero
        step(1, 0, 4'd0, 0, 0, "R8");
        step(0, 1, 4'd0, 0, 0, "R8");
        step(0, 1, 4'd1, 0, 0, "R8");
        // R7: set wins over a clear in the same cycle
        step(0, 1, 4'd5, 0, 1, "R7");
        step(0, 0, 4'd0, 0, 0, "R7");
        step(0, 0, 4'd0, 0, 1, "R7");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule